// File: doc/BRIEF.md
# Coprocessor Handshake Responder

This block sits on the coprocessor side of a host processor's coprocessor interface and answers each coprocessor instruction strobe on two active-low handshake lines, `claim_n` and `commit_n`. For any instruction it reports one of three answers. The instruction is not handled here (both lines high). The instruction is handled but cannot be committed yet (`claim_n` low, `commit_n` high), and the host busy-waits. Or the coprocessor is committed (both lines low). Pulling `commit_n` low binds the coprocessor to carry out the action, even if that action finishes much later.

Two instruction classes are handled. A data operation commits as soon as the datapath reports ready, and an operation-start pulse goes out to the execution datapath in the commit cycle. A memory-to-coprocessor transfer commits only once the datapath can accept words. The responder itself then decides how many words are transferred, using a 4-bit count field. It captures one bus word per cycle with no further handshake per word, and it marks the final data cycle by returning both lines high.

Top module: `cop_handshake_resp`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `claim_n` and `commit_n` are 1, and `cap_valid`, `cap_last` and `op_start` are 0.
- R2: A strobe sampled in idle with `op_class` 2'b00 or 2'b11 (not handled) leaves both lines high and starts nothing. The responder stays idle, so a following handled strobe is accepted normally.
- R3: A strobe sampled in idle with `op_class` 2'b01 (data operation) or 2'b10 (transfer in) while `dp_ready` is 0 gives `claim_n`=0 and `commit_n`=1 from the next cycle on. This lasts until a rising edge samples `dp_ready` as 1.
- R4: The rising edge that accepts a handled instruction with `dp_ready`=1, or that samples `dp_ready`=1 while waiting, starts exactly one commit cycle with both lines low.
- R5: `op_start` is 1 exactly in the commit cycle of a data operation, and never for a transfer.
- R6: After the commit cycle of a data operation, both lines return high and the responder is idle.
- R7: After the commit cycle of a transfer, N data cycles follow. At the rising edge ending each data cycle, `bus_data` is captured, and in the next cycle `cap_valid`=1 with `cap_data` equal to that word.
- R8: The number of words N equals `word_field` for values 1 to 15. A field of 0 means 16 words.
- R9: Both lines are low in every data cycle except the last, in which both are high. `cap_last` is 1 only with the final captured word.
- R10: While the responder is not idle, a strobe has no effect. `dp_ready` has no effect during the commit and data cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_req | input | 1 | Coprocessor instruction strobe, active high |
| op_class | input | 2 | Decoded class: 01 data operation, 10 transfer in, 00/11 not handled |
| word_field | input | CNT_W (4) | Transfer word count, 0 means 2**CNT_W |
| dp_ready | input | 1 | Datapath ready to commit / accept data |
| bus_data | input | DATA_W (32) | Incoming data bus |
| claim_n | output | 1 | Handshake line, low when the instruction is handled |
| commit_n | output | 1 | Handshake line, low when committed; both high marks the last word |
| cap_valid | output | 1 | Captured word valid |
| cap_data | output | DATA_W (32) | Captured word |
| cap_last | output | 1 | Captured word is the final one |
| op_start | output | 1 | One-cycle start pulse for a data operation |

## Verification
The bench targets single-word and sixteen-word transfers, where a counter that is off by one or reads a zero field as zero would end the transfer early or late and move the last-word marking. It drives waits of several cycles with strobes arriving mid-wait, so a responder that re-decodes a busy-period strobe or commits without ready shows up at once on the lines. It also toggles ready inside transfers and issues strobes of unhandled classes; a design that stalls words, or that claims an instruction it cannot perform, would then differ from the model cycle by cycle.

// File: rtl/cph_pkg.sv
package cph_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_DOP  = 2'b01,
    CLS_LOAD = 2'b10,
    CLS_RSVD = 2'b11
  } op_class_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_COMMIT,
    ST_DATA
  } resp_state_e;

  typedef struct packed {
    logic claim_n;
    logic commit_n;
  } hs_lines_t;

  // A zero count field stands for the largest count the field can express.
  function automatic int unsigned words_from_field(input int unsigned field,
                                                   input int unsigned field_w);
    return (field == 0) ? (32'd1 << field_w) : field;
  endfunction

  // Line levels seen by the host for each responder state.
  function automatic hs_lines_t hs_for(input resp_state_e st, input logic last_word);
    hs_lines_t r;
    case (st)
      ST_IDLE:   r = '{claim_n: 1'b1, commit_n: 1'b1};
      ST_WAIT:   r = '{claim_n: 1'b0, commit_n: 1'b1};
      ST_COMMIT: r = '{claim_n: 1'b0, commit_n: 1'b0};
      default:   r = last_word ? '{claim_n: 1'b1, commit_n: 1'b1}
                               : '{claim_n: 1'b0, commit_n: 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cph_class_decode.sv
module cph_class_decode
  import cph_pkg::*;
(
  input  logic [1:0] op_class,
  output logic       is_dop,
  output logic       is_load
);
  op_class_e cls;

  assign cls     = op_class_e'(op_class);
  assign is_dop  = (cls == CLS_DOP);
  assign is_load = (cls == CLS_LOAD);
endmodule

// File: rtl/cph_word_counter.sv
module cph_word_counter
  import cph_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] field,
  input  logic             step,
  output logic             last_word
);
  localparam int CW = CNT_W + 1;

  logic [CW-1:0] rem_q;
  logic [CW-1:0] load_val;

  assign load_val = CW'(words_from_field(32'(field), CNT_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load) begin
      rem_q <= load_val;
    end else if (step && (rem_q != '0)) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign last_word = (rem_q == CW'(1));
endmodule

// File: rtl/cph_capture.sv
module cph_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              take_last,
  input  logic [DATA_W-1:0] din,
  output logic              valid,
  output logic [DATA_W-1:0] dout,
  output logic              last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      last  <= 1'b0;
      dout  <= '0;
    end else begin
      valid <= take;
      last  <= take && take_last;
      if (take) begin
        dout <= din;
      end
    end
  end
endmodule

// File: rtl/cph_ctrl.sv
module cph_ctrl
  import cph_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic is_dop,
  input  logic is_load,
  input  logic dp_ready,
  input  logic last_word,
  output logic accept_evt,
  output logic commit_evt,
  output logic word_evt,
  output logic last_evt,
  output logic st_idle,
  output logic claim_n,
  output logic commit_n,
  output logic op_start
);
  resp_state_e state_q, state_d;
  logic        xfer_q;
  hs_lines_t   lines;

  assign st_idle    = (state_q == ST_IDLE);
  assign accept_evt = st_idle && req && (is_dop || is_load);
  assign commit_evt = (accept_evt || (state_q == ST_WAIT)) && dp_ready;
  assign word_evt   = (state_q == ST_DATA);
  assign last_evt   = word_evt && last_word;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept_evt) state_d = dp_ready ? ST_COMMIT : ST_WAIT;
      ST_WAIT:   if (commit_evt) state_d = ST_COMMIT;
      ST_COMMIT: state_d = xfer_q ? ST_DATA : ST_IDLE;
      default:   if (last_evt) state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      xfer_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_evt) begin
        xfer_q <= is_load;
      end
    end
  end

  assign lines    = hs_for(state_q, last_word);
  assign claim_n  = lines.claim_n;
  assign commit_n = lines.commit_n;
  assign op_start = (state_q == ST_COMMIT) && !xfer_q;
endmodule

// File: rtl/cop_handshake_resp.sv
module cop_handshake_resp #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_req,
  input  logic [1:0]        op_class,
  input  logic [CNT_W-1:0]  word_field,
  input  logic              dp_ready,
  input  logic [DATA_W-1:0] bus_data,
  output logic              claim_n,
  output logic              commit_n,
  output logic              cap_valid,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_last,
  output logic              op_start
);
  logic is_dop, is_load;
  logic accept_evt, commit_evt, word_evt, last_evt, st_idle;
  logic last_word;

  cph_class_decode u_dec (
    .op_class (op_class),
    .is_dop   (is_dop),
    .is_load  (is_load)
  );

  cph_word_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept_evt),
    .field     (word_field),
    .step      (word_evt),
    .last_word (last_word)
  );

  cph_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (instr_req),
    .is_dop     (is_dop),
    .is_load    (is_load),
    .dp_ready   (dp_ready),
    .last_word  (last_word),
    .accept_evt (accept_evt),
    .commit_evt (commit_evt),
    .word_evt   (word_evt),
    .last_evt   (last_evt),
    .st_idle    (st_idle),
    .claim_n    (claim_n),
    .commit_n   (commit_n),
    .op_start   (op_start)
  );

  cph_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (word_evt),
    .take_last (last_evt),
    .din       (bus_data),
    .valid     (cap_valid),
    .dout      (cap_data),
    .last      (cap_last)
  );
endmodule

// File: rtl/cop_handshake_resp_chk.sv
module cop_handshake_resp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       instr_req,
  input logic [1:0] op_class,
  input logic       dp_ready,
  input logic       claim_n,
  input logic       commit_n,
  input logic       cap_valid,
  input logic       cap_last,
  input logic       op_start,
  input logic       st_idle,
  input logic       commit_evt
);
  assert_unhandled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && instr_req && (op_class == 2'b00 || op_class == 2'b11))
      |=> (claim_n && commit_n));

  assert_wait_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!claim_n && commit_n && !dp_ready) |=> (!claim_n && commit_n));

  assert_commit_follows_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (!claim_n && !commit_n));

  assert_commit_implies_claim_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_n |-> !claim_n);

  assert_start_in_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> (!claim_n && !commit_n));

  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);

  assert_dop_returns_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> (claim_n && commit_n));

  assert_last_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_last |-> cap_valid);

  assert_last_lines_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_last |-> ($past(claim_n) && $past(commit_n)));
endmodule

bind cop_handshake_resp cop_handshake_resp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr_req  (instr_req),
  .op_class   (op_class),
  .dp_ready   (dp_ready),
  .claim_n    (claim_n),
  .commit_n   (commit_n),
  .cap_valid  (cap_valid),
  .cap_last   (cap_last),
  .op_start   (op_start),
  .st_idle    (st_idle),
  .commit_evt (commit_evt)
);

// File: tb/cop_handshake_resp_test.sv
`timescale 1ns/1ps
module cop_handshake_resp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_req = 1'b0;
  logic [1:0]  op_class = 2'b00;
  logic [3:0]  word_field = 4'd0;
  logic        dp_ready = 1'b0;
  logic [31:0] bus_data = 32'h0;
  logic        claim_n, commit_n, cap_valid, cap_last, op_start;
  logic [31:0] cap_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int cyc = 0;

  // reference model state: 0 idle, 1 wait, 2 commit, 3 data
  int          m_state = 0;
  bit          m_xfer = 0;
  int          m_n = 0;
  int          m_k = 0;
  bit          e_valid = 0;
  bit          e_last = 0;
  logic [31:0] e_data = 32'h0;

  int cnt_cap = 0, cnt_start = 0, cnt_last = 0;

  always #10 clk = ~clk;

  cop_handshake_resp uut (
    .clk(clk), .rst_n(rst_n), .instr_req(instr_req), .op_class(op_class),
    .word_field(word_field), .dp_ready(dp_ready), .bus_data(bus_data),
    .claim_n(claim_n), .commit_n(commit_n), .cap_valid(cap_valid),
    .cap_data(cap_data), .cap_last(cap_last), .op_start(op_start)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // bus pattern changes every cycle
  always @(negedge clk) begin
    cyc <= cyc + 1;
    bus_data <= 32'h3C00_0000 ^ (32'(cyc) * 32'h0001_0203);
  end

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_k = 0; e_valid = 0; e_last = 0;
    end else begin
      e_valid = 0;
      e_last = 0;
      case (m_state)
        0: if (instr_req && (op_class == 2'b01 || op_class == 2'b10)) begin
             m_xfer = (op_class == 2'b10);
             m_n = (word_field == 0) ? 16 : int'(word_field);
             m_state = dp_ready ? 2 : 1;
           end
        1: if (dp_ready) m_state = 2;
        2: begin m_k = 0; m_state = m_xfer ? 3 : 0; end
        default: begin
          e_valid = 1;
          e_data = bus_data;
          m_k++;
          e_last = (m_k == m_n);
          if (m_k == m_n) m_state = 0;
        end
      endcase
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    bit ec, em, es;
    string hreq;
    case (m_state)
      0: begin ec = 1; em = 1; hreq = "R2"; end
      1: begin ec = 0; em = 1; hreq = "R3"; end
      2: begin ec = 0; em = 0; hreq = "R4"; end
      default: begin ec = (m_k + 1 == m_n); em = ec; hreq = "R9"; end
    endcase
    es = (m_state == 2) && !m_xfer;
    if (!rst_n) begin
      check(claim_n === 1'b1 && commit_n === 1'b1, "R1", "lines in reset",
            {30'b0, claim_n, commit_n}, 32'h3);
      check(cap_valid === 1'b0 && op_start === 1'b0 && cap_last === 1'b0, "R1",
            "outputs in reset", {29'b0, cap_valid, op_start, cap_last}, 32'h0);
    end else begin
      check(claim_n === ec, hreq, "claim_n", 32'(claim_n), 32'(ec));
      check(commit_n === em, hreq, "commit_n", 32'(commit_n), 32'(em));
      check(op_start === es, "R5", "op_start", 32'(op_start), 32'(es));
      check(cap_valid === e_valid, "R7", "cap_valid", 32'(cap_valid), 32'(e_valid));
      if (e_valid) check(cap_data === e_data, "R7", "cap_data", cap_data, e_data);
      check(cap_last === e_last, "R9", "cap_last", 32'(cap_last), 32'(e_last));
      if (cap_valid === 1'b1) cnt_cap++;
      if (op_start === 1'b1) cnt_start++;
      if (cap_last === 1'b1) cnt_last++;
    end
  end

  // issue one instruction; ready rises after 'delay' sampled edges
  task automatic do_op(input logic [1:0] cls, input logic [3:0] fld, input int delay,
                       input bit poke_busy, input bit wiggle_ready);
    int c0, s0, l0, words;
    bit handled;
    handled = (cls == 2'b01 || cls == 2'b10);
    words = (fld == 0) ? 16 : int'(fld);
    @(negedge clk); #1;
    c0 = cnt_cap; s0 = cnt_start; l0 = cnt_last;
    instr_req = 1; op_class = cls; word_field = fld; dp_ready = (delay == 0);
    @(negedge clk); #1;
    instr_req = 0;
    for (int i = 1; i < delay; i++) begin
      if (poke_busy) begin instr_req = 1; op_class = 2'b10; word_field = 4'd3; end
      @(negedge clk); #1;
      instr_req = 0;
    end
    dp_ready = 1;
    for (int i = 0; i < 40; i++) begin
      if (m_state == 0) break;
      if (poke_busy) begin instr_req = (i % 2 == 0); op_class = 2'b01; end
      if (wiggle_ready && m_state == 3) dp_ready = (i % 3 != 0);
      @(negedge clk); #1;
    end
    instr_req = 0;
    dp_ready = 0;
    @(negedge clk); #1;
    if (cls == 2'b10)
      check(cnt_cap - c0 == words, "R8", "words captured", 32'(cnt_cap - c0), 32'(words));
    else
      check(cnt_cap - c0 == 0, "R6", "words captured", 32'(cnt_cap - c0), 32'h0);
    check(cnt_start - s0 == ((cls == 2'b01) ? 1 : 0), "R5", "start pulses",
          32'(cnt_start - s0), (cls == 2'b01) ? 32'h1 : 32'h0);
    check(cnt_last - l0 == ((cls == 2'b10) ? 1 : 0), "R9", "last marks",
          32'(cnt_last - l0), (cls == 2'b10) ? 32'h1 : 32'h0);
    if (!handled)
      check(claim_n === 1'b1 && commit_n === 1'b1, "R2", "lines after unhandled",
            {30'b0, claim_n, commit_n}, 32'h3);
    if (poke_busy)
      check(m_state == 0 && claim_n === 1'b1, "R10", "idle after busy strobes",
            32'(claim_n), 32'h1);
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(claim_n === 1'b1 && commit_n === 1'b1 && op_start === 1'b0 && cap_valid === 1'b0,
          "R1", "state after reset", {28'b0, claim_n, commit_n, op_start, cap_valid}, 32'hC);
    do_op(2'b00, 4'd2, 0, 0, 0);   // R2
    do_op(2'b11, 4'd5, 0, 0, 0);   // R2
    do_op(2'b01, 4'd0, 0, 0, 0);   // R4 R5 R6
    do_op(2'b01, 4'd0, 4, 1, 0);   // R3 R10
    do_op(2'b10, 4'd1, 0, 0, 0);   // R8 single word
    do_op(2'b10, 4'd5, 2, 0, 1);   // R7 R10
    do_op(2'b10, 4'd0, 0, 1, 1);   // R8 sixteen words, R10
    do_op(2'b10, 4'd15, 3, 1, 0);  // R8 R9
    do_op(2'b01, 4'd7, 1, 0, 0);   // R3 short wait
    do_op(2'b10, 4'd2, 0, 0, 0);   // R9 two words
    repeat (3) @(negedge clk);
    wrap_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    wrap_up();
  end
endmodule